// File: doc/BRIEF.md
# Bidirectional Dual-Bus Register Bank

This block is a bank of general-purpose registers sitting between two shared data buses, called A and B. Each bus has its own port into the bank. On every clock the controller gives each port a register number and an operation. The operation is one of three: leave the bus alone, put the chosen register's contents onto the bus, or capture the bus value into the chosen register. The two ports work independently and at the same time. Either bus can feed the bank while the other reads from it, both can read, or both can write.

Tristate buses are modelled with three signals per port: an output value, an output enable and an input value. The enclosing datapath resolves these into a real bus. The bank does not police conflicting requests; that is the controller's job. Two cases are still made deterministic. If both ports write the same register, the A port's value is kept. A parameter decides whether one register may be put on both buses in the same cycle.

Top module: `dual_bus_regbank`

## Requirements
- R1: After reset every register holds zero, so a drive of any register before any load shows zero on the bus.
- R2: An A-port load (op code 2'b10) writes `a_bus_in` into the register numbered `a_sel` at the rising clock edge, and that value is visible from the following cycle.
- R3: A B-port load (op code 2'b10) writes `b_bus_in` into the register numbered `b_sel` at the rising clock edge, unless the A port loads the same register in that cycle.
- R4: Loads on both ports in one cycle that name different registers both take effect.
- R5: Loads on both ports in one cycle that name the same register leave the A-port value in that register.
- R6: A port's output enable is high exactly when its op code is drive (2'b01). While it is high the output carries the selected register's contents, combinationally from `*_sel`. While it is low the output is all zeros.
- R7: With dual drive allowed (`ALLOW_DUAL_DRIVE=1`), both ports may drive in the same cycle, and they show identical values when they name the same register.
- R8: When one port loads a register and the other drives that same register in the same cycle, the driven value is the contents from before the edge. The new value appears from the next cycle.
- R9: Op codes 2'b00 (idle) and 2'b11 (reserved) change no register and assert no output enable.
- R10: With `ALLOW_DUAL_DRIVE=0`, if both ports request drive of the same register, only the A port drives. The B port's enable stays low and its output stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; loads happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears every register |
| a_op | input | 2 | A-port operation: 00 idle, 01 drive, 10 load, 11 reserved (idle) |
| a_sel | input | SELW | Register number for the A port |
| a_bus_in | input | WIDTH | Value present on the A bus, used by a load |
| a_bus_out | output | WIDTH | Value the bank puts on the A bus |
| a_bus_oe | output | 1 | Bank drives the A bus |
| b_op | input | 2 | B-port operation, same encoding as `a_op` |
| b_sel | input | SELW | Register number for the B port |
| b_bus_in | input | WIDTH | Value present on the B bus, used by a load |
| b_bus_out | output | WIDTH | Value the bank puts on the B bus |
| b_bus_oe | output | 1 | Bank drives the B bus |

## Verification
The assertions check on every cycle that:
- a disabled output is zero;
- both ports agree when they drive one register;
- a value loaded from either bus is what a drive of that register returns one cycle later, with A winning a shared load;
- contents hold when nothing loads;
- with dual drive forbidden, the B enable is never granted on the A port's register.

Only the bench's directed scenarios can show a few things: the all-zero reset state across the whole bank, the old-value result of loading and driving one register in the same cycle, and that the reserved code touches nothing. A second instance built with dual drive forbidden, together with a long random run against the reference model, covers the arbitration from the ports.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_DRIVE = 2'b01,
      OP_LOAD  = 2'b10,
      OP_RSVD  = 2'b11
   } bus_op_e;

   function automatic logic op_is_drive(input logic [1:0] op);
      return op == OP_DRIVE;
   endfunction

   function automatic logic op_is_load(input logic [1:0] op);
      return op == OP_LOAD;
   endfunction
endpackage

// File: rtl/rb_port_decode.sv
module rb_port_decode
   import regbank_pkg::*;
#(
   parameter int NREGS = 8,
   parameter int SELW  = 3
) (
   input  logic [1:0]       op,
   input  logic [SELW-1:0]  sel,
   output logic             drive,
   output logic [NREGS-1:0] load_vec
);
   logic load;

   assign drive = op_is_drive(op);
   assign load  = op_is_load(op);

   for (genvar i = 0; i < NREGS; i++) begin : g_ld
      assign load_vec[i] = load && (sel == SELW'(i));
   end
endmodule

// File: rtl/rb_reg_cell.sv
module rb_reg_cell #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_a,
   input  logic             ld_b,
   input  logic [WIDTH-1:0] din_a,
   input  logic [WIDTH-1:0] din_b,
   output logic [WIDTH-1:0] q
);
   // A port has priority on a shared load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (ld_a) q <= din_a;
      else if (ld_b) q <= din_b;
   end
endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux #(
   parameter int NREGS = 8,
   parameter int WIDTH = 8,
   parameter int SELW  = 3
) (
   input  logic [NREGS-1:0][WIDTH-1:0] regs,
   input  logic [SELW-1:0]             sel,
   input  logic                        en,
   output logic [WIDTH-1:0]            dout
);
   always_comb begin
      dout = '0;
      if (en) dout = regs[sel];
   end
endmodule

// File: rtl/dual_bus_regbank.sv
module dual_bus_regbank #(
   parameter int NREGS            = 8,
   parameter int WIDTH            = 8,
   parameter bit ALLOW_DUAL_DRIVE = 1'b1,
   localparam int SELW            = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       a_op,
   input  logic [SELW-1:0]  a_sel,
   input  logic [WIDTH-1:0] a_bus_in,
   output logic [WIDTH-1:0] a_bus_out,
   output logic             a_bus_oe,
   input  logic [1:0]       b_op,
   input  logic [SELW-1:0]  b_sel,
   input  logic [WIDTH-1:0] b_bus_in,
   output logic [WIDTH-1:0] b_bus_out,
   output logic             b_bus_oe
);
   if (NREGS < 2) begin : g_bad_nregs
      $error("dual_bus_regbank: NREGS must be at least 2");
   end
   if ((NREGS & (NREGS - 1)) != 0) begin : g_bad_pow2
      $error("dual_bus_regbank: NREGS must be a power of two");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dual_bus_regbank: WIDTH must be positive");
   end

   logic                        a_drv, b_drv, b_grant;
   logic [NREGS-1:0]            a_ld, b_ld;
   logic [NREGS-1:0][WIDTH-1:0] bank_q;

   rb_port_decode #(.NREGS(NREGS), .SELW(SELW)) u_dec_a (
      .op(a_op), .sel(a_sel), .drive(a_drv), .load_vec(a_ld));
   rb_port_decode #(.NREGS(NREGS), .SELW(SELW)) u_dec_b (
      .op(b_op), .sel(b_sel), .drive(b_drv), .load_vec(b_ld));

   for (genvar i = 0; i < NREGS; i++) begin : g_cell
      rb_reg_cell #(.WIDTH(WIDTH)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .ld_a(a_ld[i]), .ld_b(b_ld[i]),
         .din_a(a_bus_in), .din_b(b_bus_in),
         .q(bank_q[i]));
   end

   if (ALLOW_DUAL_DRIVE) begin : g_dual_ok
      assign b_grant = b_drv;
   end else begin : g_dual_block
      assign b_grant = b_drv && !(a_drv && (a_sel == b_sel));
   end

   rb_read_mux #(.NREGS(NREGS), .WIDTH(WIDTH), .SELW(SELW)) u_mux_a (
      .regs(bank_q), .sel(a_sel), .en(a_drv), .dout(a_bus_out));
   rb_read_mux #(.NREGS(NREGS), .WIDTH(WIDTH), .SELW(SELW)) u_mux_b (
      .regs(bank_q), .sel(b_sel), .en(b_grant), .dout(b_bus_out));

   assign a_bus_oe = a_drv;
   assign b_bus_oe = b_grant;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
   parameter int NREGS            = 8,
   parameter int WIDTH            = 8,
   parameter bit ALLOW_DUAL_DRIVE = 1'b1,
   localparam int SELW            = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       a_op,
   input logic [SELW-1:0]  a_sel,
   input logic [WIDTH-1:0] a_bus_in,
   input logic [WIDTH-1:0] a_bus_out,
   input logic             a_bus_oe,
   input logic [1:0]       b_op,
   input logic [SELW-1:0]  b_sel,
   input logic [WIDTH-1:0] b_bus_in,
   input logic [WIDTH-1:0] b_bus_out,
   input logic             b_bus_oe
);
   // R6: disabled outputs are zero
   a_r6_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !a_bus_oe |-> a_bus_out == '0);
   a_r6_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !b_bus_oe |-> b_bus_out == '0);

   // R7: both ports driving one register agree
   a_r7_same_value: assert property (@(posedge clk) disable iff (!rst_n)
      (a_bus_oe && b_bus_oe && a_sel == b_sel) |-> a_bus_out == b_bus_out);

   // R2 / R5: an A load is read back next cycle (A wins shared loads)
   a_r2_load_a: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(a_op == 2'b10) && a_bus_oe && a_sel == $past(a_sel))
      |-> a_bus_out == $past(a_bus_in));

   // R3: a B load without a colliding A load is read back next cycle
   a_r3_load_b: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(b_op == 2'b10)
       && !($past(a_op == 2'b10) && $past(a_sel) == $past(b_sel))
       && b_bus_oe && b_sel == $past(b_sel))
      |-> b_bus_out == $past(b_bus_in));

   // R9: with no load anywhere, a register read twice stays put
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(a_bus_oe) && a_bus_oe && a_sel == $past(a_sel)
       && $past(a_op != 2'b10) && $past(b_op != 2'b10))
      |-> a_bus_out == $past(a_bus_out));

   if (!ALLOW_DUAL_DRIVE) begin : g_nodual
      // R10: B never granted the register A is driving
      a_r10_no_dual: assert property (@(posedge clk) disable iff (!rst_n)
         a_bus_oe |-> !(b_bus_oe && b_sel == a_sel));
   end
endmodule

bind dual_bus_regbank regbank_chk #(
   .NREGS(NREGS), .WIDTH(WIDTH), .ALLOW_DUAL_DRIVE(ALLOW_DUAL_DRIVE)
) u_regbank_chk (.*);

// File: tb/test_dual_bus_regbank.sv
module test_dual_bus_regbank;
   localparam int CLK_P = 10;
   localparam int NR    = 8;
   localparam int W     = 8;
   localparam int SW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic [1:0]    a_op = 2'b00, b_op = 2'b00;
   logic [SW-1:0] a_sel = '0, b_sel = '0;
   logic [W-1:0]  a_in = '0, b_in = '0;
   logic [W-1:0]  a_out, b_out, n_a_out, n_b_out;
   logic          a_oe, b_oe, n_a_oe, n_b_oe;

   dual_bus_regbank #(.NREGS(NR), .WIDTH(W), .ALLOW_DUAL_DRIVE(1'b1)) i_dual_bus_regbank (
      .clk(clk), .rst_n(rst_n),
      .a_op(a_op), .a_sel(a_sel), .a_bus_in(a_in), .a_bus_out(a_out), .a_bus_oe(a_oe),
      .b_op(b_op), .b_sel(b_sel), .b_bus_in(b_in), .b_bus_out(b_out), .b_bus_oe(b_oe));

   dual_bus_regbank #(.NREGS(NR), .WIDTH(W), .ALLOW_DUAL_DRIVE(1'b0)) i_dual_bus_regbank_nodual (
      .clk(clk), .rst_n(rst_n),
      .a_op(a_op), .a_sel(a_sel), .a_bus_in(a_in), .a_bus_out(n_a_out), .a_bus_oe(n_a_oe),
      .b_op(b_op), .b_sel(b_sel), .b_bus_in(b_in), .b_bus_out(n_b_out), .b_bus_oe(n_b_oe));

   int total = 0;
   int bad = 0;
   logic [W-1:0] model [NR];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock: apply inputs, compare outputs to the model, then update it on the edge
   task automatic cyc(input string tag, input logic [1:0] aop, input int asel, input int ain,
                      input logic [1:0] bop, input int bsel, input int bin);
      logic ea_oe, eb_oe, en_oe;
      @(negedge clk);
      a_op = aop; a_sel = SW'(asel); a_in = W'(ain);
      b_op = bop; b_sel = SW'(bsel); b_in = W'(bin);
      #1;
      ea_oe = (aop == 2'b01);
      eb_oe = (bop == 2'b01);
      en_oe = eb_oe && !(ea_oe && asel == bsel);
      check({tag, " R6 a_oe"}, 32'(a_oe), 32'(ea_oe));
      check({tag, " R6 b_oe"}, 32'(b_oe), 32'(eb_oe));
      check({tag, " R6 a_out"}, 32'(a_out), ea_oe ? 32'(model[asel]) : 32'd0);
      check({tag, " R7 b_out"}, 32'(b_out), eb_oe ? 32'(model[bsel]) : 32'd0);
      check({tag, " R10 n_b_oe"}, 32'(n_b_oe), 32'(en_oe));
      check({tag, " R10 n_b_out"}, 32'(n_b_out), en_oe ? 32'(model[bsel]) : 32'd0);
      check({tag, " R10 n_a_out"}, 32'(n_a_out), ea_oe ? 32'(model[asel]) : 32'd0);
      @(posedge clk);
      if (bop == 2'b10) model[bsel] = W'(bin);
      if (aop == 2'b10) model[asel] = W'(ain);   // R5: A last, so A wins
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_P * 50000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NR; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: all registers read as zero after reset
      for (int i = 0; i < NR; i++) cyc("R1", 2'b01, i, 0, 2'b01, NR - 1 - i, 0);

      // R2: fill through the A bus, read back on both buses
      for (int i = 0; i < NR; i++) cyc("R2", 2'b10, i, 8'h11 * (i + 1), 2'b00, 0, 0);
      for (int i = 0; i < NR; i++) cyc("R2 rd", 2'b01, i, 0, 2'b01, i, 0);

      // R3: B-port loads
      cyc("R3", 2'b00, 0, 0, 2'b10, 5, 8'hC3);
      cyc("R3 rd", 2'b00, 0, 0, 2'b01, 5, 0);

      // R4: both ports load different registers
      cyc("R4", 2'b10, 1, 8'hA1, 2'b10, 2, 8'hB2);
      cyc("R4 rd", 2'b01, 1, 0, 2'b01, 2, 0);

      // R5: both ports load the same register, A value kept
      cyc("R5", 2'b10, 4, 8'h4A, 2'b10, 4, 8'h4B);
      cyc("R5 rd", 2'b01, 4, 0, 2'b00, 0, 0);

      // R8: load on one bus, drive same register on the other
      cyc("R8", 2'b10, 3, 8'h5A, 2'b01, 3, 0);
      cyc("R8 new", 2'b00, 0, 0, 2'b01, 3, 0);
      cyc("R8 b", 2'b01, 6, 0, 2'b10, 6, 8'h66);
      cyc("R8 b new", 2'b01, 6, 0, 2'b00, 0, 0);

      // R9: idle and reserved codes alter nothing
      cyc("R9", 2'b11, 0, 8'hFF, 2'b11, 7, 8'hFF);
      cyc("R9", 2'b00, 7, 8'hEE, 2'b00, 0, 8'hEE);
      for (int i = 0; i < NR; i++) cyc("R9 rd", 2'b01, i, 0, 2'b01, i, 0);

      // R7 / R10: both drive the same register
      cyc("R7", 2'b01, 2, 0, 2'b01, 2, 0);
      cyc("R10", 2'b01, 5, 0, 2'b01, 5, 0);

      // Random mix against the model
      for (int k = 0; k < 400; k++)
         cyc("rand", 2'($urandom), int'($urandom % NR), int'($urandom % 256),
             2'($urandom), int'($urandom % NR), int'($urandom % 256));

      finish_run();
   end
endmodule